// File: doc/BRIEF.md
# GPU Power and Reset Sequencer

This block controls the power state of a graphics core domain and steps it through isolation, soft reset and power-down. Software reaches it through a simple register bus. Two 32-bit control/status words are mapped on that bus: a normal-world word at offset 0x000 and a trusted-world word at offset 0x400. A write to a command bit or to the state field starts a sequence. Software then polls the 4-bit state code until the sequence completes. The block drives three outputs to the core (isolate, reset and power-enable) and raises an interrupt each time a sequence finishes.

When its own reset is released, the block starts with the domain powered off. Software must therefore issue a clear-power-off command from the trusted word before the core can be used.

A soft reset passes through its own isolating state before the reset pulse. A power-down passes through a different isolating state before reaching the powered-off state. Each isolating state holds the isolate output for a parameterised number of cycles (default 16) so the core's bus traffic can drain. Lock, secure-mode and mode-change bits are kept as plain sticky flags.

Top module: `gpu_pwr_seq`

## Requirements
- R1: After reset the state code is 0xD (powered off), core_isolate=1, core_reset=1, core_power_en=0 and the interrupt bit is 0.
- R2: A write or read at bus_addr 0x000 selects the normal-world word and 0x400 selects the trusted-world word. Both words read back the same live value. The fields are: interrupt [31], lock [28], secure-exit [26], secure-enter [24], their-exit [22], their-enter [21], our-exit [20], step index [16:10], hub status [9:8], new mode [7:6], old mode [5:4], state [3:0]. Any other address reads 0 and ignores writes.
- R3: While the state is idle (0x0), a write of 0x4 into bits [3:0] of the normal-world word starts a soft reset. The state is then 0xA for ISOLATE_CYCLES cycles, 0xB for exactly 8 cycles, and then 0x0. The step index is 1 in 0xA, 2 in 0xB and 0 in idle.
- R4: While idle, writing 1 to bit 30 of the trusted-world word starts power-down. The state is 0xC for ISOLATE_CYCLES cycles with step index 3, then 0xD with step index 4.
- R5: While the state is 0xD, writing 1 to bit 29 of the trusted-world word returns the state to 0x0 on the next cycle.
- R6: core_isolate is 1 in states 0xA, 0xB, 0xC and 0xD. core_reset is 1 in states 0xB and 0xD. core_power_en is 0 only in state 0xD.
- R7: A request is ignored, and the state field and outputs stay unchanged, when: a reset or power-off request arrives outside idle; a clear-power-off arrives outside 0xD; a reset pattern is written to the trusted word; or bit 30 is written to the normal word.
- R8: The interrupt bit and core_irq set on each sequence completion: 0xB to 0x0, 0xC to 0xD, and 0xD to 0x0. Writing 1 to bit 31 of either word clears them. Completion wins over a clear in the same cycle.
- R9: The sticky flags are written only through the trusted-world word. Bit 28 sets lock and bit 27 clears it. Bit 26 sets secure-exit and bit 25 clears it. Bit 24 sets secure-enter and bit 23 clears it. Bits 22 and 21 set their-exit and their-enter. Bit 20 sets our-exit and bit 19 clears it. When set and clear arrive in the same write, clear wins.
- R10: Command bits 30, 29, 27, 25, 23 and 19 always read back as 0.
- R11: New mode is 0 in state 0xD, 2 when secure-enter is set, and 1 otherwise. Old mode holds the new-mode value from just before the most recent state change (0 after reset).
- R12: Hub status bit 8 equals core_power_en. Hub status bit 9 equals the inverse of core_isolate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | Access is a write |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| core_isolate | output | 1 | Isolates the core from the fabric |
| core_reset | output | 1 | Holds the core in reset |
| core_power_en | output | 1 | Enables core domain power |
| core_irq | output | 1 | Sequence-completion interrupt |

## Verification
The embedded assertions check the legal successor of every intermediate state on every cycle. They also check that reset and power-off always come with isolation, that the reset state lasts exactly eight cycles, and that the interrupt is raised when a soft reset completes.

Only the bench scenarios can show the following:
- that bus writes are decoded correctly per world and per state;
- that misplaced requests are ignored;
- that the sticky flags set and clear with clear winning;
- the read-back field values and mode history;
- the exact isolation dwell time seen at the output pins.

// File: rtl/gpu_pwr_seq.sv
module gpu_pwr_seq #(
  parameter int ADDR_W         = 12,
  parameter int ISOLATE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              core_isolate,
  output logic              core_reset,
  output logic              core_power_en,
  output logic              core_irq
);

  localparam int RESET_CYCLES = 8;
  localparam int MAX_WAIT     = (ISOLATE_CYCLES > RESET_CYCLES) ? ISOLATE_CYCLES : RESET_CYCLES;
  localparam int CNT_W        = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] ISO_LAST = CNT_W'(ISOLATE_CYCLES - 1);
  localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RESET_CYCLES - 1);
  localparam logic [ADDR_W-1:0] NORM_OFS  = '0;
  localparam logic [ADDR_W-1:0] TRUST_OFS = ADDR_W'(11'h400);

  typedef enum logic [3:0] {
    S_IDLE  = 4'h0,
    S_ISO_R = 4'hA,
    S_RST   = 4'hB,
    S_ISO_O = 4'hC,
    S_OFF   = 4'hD
  } state_t;

  state_t           st, nxt;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             seq_done;
  logic             irq_q, lock_q, sec_exit_q, sec_enter_q, th_exit_q, th_enter_q, our_exit_q;
  logic [1:0]       new_mode, old_mode;
  logic [6:0]       step;
  logic [31:0]      word;

  wire wr        = bus_valid & bus_write;
  wire sel_norm  = bus_addr == NORM_OFS;
  wire sel_trust = bus_addr == TRUST_OFS;
  wire wr_norm   = wr & sel_norm;
  wire wr_trust  = wr & sel_trust;
  wire req_reset = wr_norm & (bus_wdata[3:0] == 4'h4);
  wire req_off   = wr_trust & bus_wdata[30];
  wire req_on    = wr_trust & bus_wdata[29];

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[18:4];

  always_comb begin
    nxt      = st;
    cnt_n    = cnt + 1'b1;
    seq_done = 1'b0;
    case (st)
      S_IDLE: begin
        cnt_n = '0;
        if (req_reset)    nxt = S_ISO_R;
        else if (req_off) nxt = S_ISO_O;
      end
      S_ISO_R: if (cnt == ISO_LAST) begin
        nxt   = S_RST;
        cnt_n = '0;
      end
      S_RST: if (cnt == RST_LAST) begin
        nxt      = S_IDLE;
        cnt_n    = '0;
        seq_done = 1'b1;
      end
      S_ISO_O: if (cnt == ISO_LAST) begin
        nxt      = S_OFF;
        cnt_n    = '0;
        seq_done = 1'b1;
      end
      S_OFF: begin
        cnt_n = '0;
        if (req_on) begin
          nxt      = S_IDLE;
          seq_done = 1'b1;
        end
      end
      default: begin
        nxt   = S_OFF;
        cnt_n = '0;
      end
    endcase
  end

  always_comb begin
    case (st)
      S_ISO_R: step = 7'd1;
      S_RST:   step = 7'd2;
      S_ISO_O: step = 7'd3;
      S_OFF:   step = 7'd4;
      default: step = 7'd0;
    endcase
  end

  assign new_mode = (st == S_OFF) ? 2'd0 : (sec_enter_q ? 2'd2 : 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_OFF;
      cnt      <= '0;
      old_mode <= 2'd0;
      irq_q    <= 1'b0;
    end else begin
      st  <= nxt;
      cnt <= cnt_n;
      if (nxt != st) old_mode <= new_mode;
      if (seq_done)                                  irq_q <= 1'b1;
      else if ((wr_norm | wr_trust) & bus_wdata[31]) irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q      <= 1'b0;
      sec_exit_q  <= 1'b0;
      sec_enter_q <= 1'b0;
      th_exit_q   <= 1'b0;
      th_enter_q  <= 1'b0;
      our_exit_q  <= 1'b0;
    end else if (wr_trust) begin
      lock_q      <= (lock_q      | bus_wdata[28]) & ~bus_wdata[27];
      sec_exit_q  <= (sec_exit_q  | bus_wdata[26]) & ~bus_wdata[25];
      sec_enter_q <= (sec_enter_q | bus_wdata[24]) & ~bus_wdata[23];
      th_exit_q   <= th_exit_q  | bus_wdata[22];
      th_enter_q  <= th_enter_q | bus_wdata[21];
      our_exit_q  <= (our_exit_q  | bus_wdata[20]) & ~bus_wdata[19];
    end
  end

  assign core_isolate  = st != S_IDLE;
  assign core_reset    = (st == S_RST) | (st == S_OFF);
  assign core_power_en = st != S_OFF;
  assign core_irq      = irq_q;

  assign word = {irq_q, 2'b00, lock_q, 1'b0, sec_exit_q, 1'b0, sec_enter_q, 1'b0,
                 th_exit_q, th_enter_q, our_exit_q, 1'b0, 2'b00, step,
                 ~core_isolate, core_power_en, new_mode, old_mode, st};
  assign bus_rdata = (sel_norm | sel_trust) ? word : 32'd0;

  logic [CNT_W-1:0] rst_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rst_run <= '0;
    else if (st == S_RST)   rst_run <= rst_run + 1'b1;
    else                    rst_run <= '0;
  end

  p_reset_isolated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |-> core_isolate);
  p_off_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !core_power_en |-> (core_reset && core_isolate));
  p_iso_r_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_ISO_R |=> (st == S_ISO_R || st == S_RST));
  p_rst_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_RST |=> (st == S_RST || st == S_IDLE));
  p_iso_o_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_ISO_O |=> (st == S_ISO_O || st == S_OFF));
  p_off_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_OFF |=> (st == S_OFF || st == S_IDLE));
  p_rst_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_run <= CNT_W'(RESET_CYCLES));
  p_rst_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && $past(st) == S_RST) |-> rst_run == CNT_W'(RESET_CYCLES));
  p_done_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && $past(st) == S_RST) |-> core_irq);

endmodule

// File: tb/test_gpu_pwr_seq.sv
module test_gpu_pwr_seq;
  localparam int ISO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        core_isolate, core_reset, core_power_en, core_irq;

  gpu_pwr_seq #(.ADDR_W(12), .ISOLATE_CYCLES(ISO)) i_gpu_pwr_seq (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_isolate(core_isolate), .core_reset(core_reset),
    .core_power_en(core_power_en), .core_irq(core_irq));

  always #2.5 clk = ~clk;

  typedef struct { logic [2:0] o; int d; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic push(input logic [2:0] o, input int d);
    exp_t e;
    e.o = o; e.d = d;
    q.push_back(e);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin : monitor
    logic [2:0] last, cur;
    int run, pdur;
    exp_t e;
    wait (rst_n === 1'b1);
    last = 3'b110; run = 0; pdur = 0;
    forever begin
      @(negedge clk);
      cur = {core_isolate, core_reset, core_power_en};
      if (cur !== last) begin
        if (pdur != 0) chk(run, pdur, "R3/R4 dwell length of previous output state");
        if (q.size() == 0) chk({29'd0, cur}, {29'd0, last}, "R7 unexpected output change");
        else begin
          e = q.pop_front();
          chk({29'd0, cur}, {29'd0, e.o}, "R6 output triple {iso,rst,pwr}");
          pdur = e.d;
        end
        run = 1; last = cur;
      end else run++;
    end
  end

  task automatic run_tests;
    logic [31:0] r, r2;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1
    chk({29'd0, core_isolate, core_reset, core_power_en}, 32'd6, "R1 outputs after reset");
    rd(12'h000, r);
    chk(r[3:0], 4'hD, "R1 state after reset");
    chk(r[31], 1'b0, "R1 interrupt after reset");
    chk(r[16:10], 7'd4, "R2 step index in off");
    chk(r[7:6], 2'd0, "R11 new mode in off");
    // R7: reset while off
    wr(12'h000, 32'h4);
    rd(12'h000, r);
    chk(r[3:0], 4'hD, "R7 reset ignored when off");
    // R5 power up
    push(3'b001, 0);
    wr(12'h400, 32'h1 << 29);
    rd(12'h000, r);
    chk(r[3:0], 4'h0, "R5 clear-power-off to idle");
    chk(r[31], 1'b1, "R8 interrupt after power-up");
    chk(core_irq, 1'b1, "R8 core_irq after power-up");
    chk(r[7:4], 4'b0100, "R11 new=1 old=0 after power-up");
    chk(r[9:8], 2'b11, "R12 hub status idle");
    rd(12'h400, r2);
    chk(r2, r, "R2 both words read the same");
    // R8 clear
    wr(12'h000, 32'h1 << 31);
    rd(12'h000, r);
    chk(r[31], 1'b0, "R8 interrupt cleared");
    // R3 soft reset timing
    push(3'b101, ISO); push(3'b111, 8); push(3'b001, 0);
    wr(12'h000, 32'h4);
    rd(12'h000, r);
    chk(r[3:0], 4'hA, "R3 isolating for reset");
    chk(r[16:10], 7'd1, "R3 step index 1");
    chk(r[9:8], 2'b01, "R12 hub status isolating");
    repeat (ISO) @(negedge clk);
    rd(12'h000, r);
    chk(r[3:0], 4'hB, "R3 resetting after isolation wait");
    chk(r[16:10], 7'd2, "R3 step index 2");
    repeat (8) @(negedge clk);
    rd(12'h000, r);
    chk(r[3:0], 4'h0, "R3 idle after 8 reset cycles");
    chk(r[31], 1'b1, "R8 interrupt after soft reset");
    // R7 requests during a sequence
    wr(12'h000, 32'h1 << 31);
    push(3'b101, ISO); push(3'b111, 8); push(3'b001, 0);
    wr(12'h000, 32'h4);
    wr(12'h400, 32'h1 << 30);
    wr(12'h000, 32'h4);
    wr(12'h400, 32'h1 << 29);
    for (int i = 0; i < 100; i++) begin
      rd(12'h000, r);
      if (r[3:0] == 4'h0) break;
      @(negedge clk);
    end
    chk(r[3:0], 4'h0, "R7 busy requests ignored, reset completes");
    // R7 wrong-world requests
    wr(12'h000, 32'h1 << 31);
    wr(12'h400, 32'h4);
    rd(12'h000, r);
    chk(r[3:0], 4'h0, "R7 reset via trusted word ignored");
    wr(12'h000, 32'h1 << 30);
    rd(12'h000, r);
    chk(r[3:0], 4'h0, "R7 power-off via normal word ignored");
    wr(12'h400, 32'h1 << 29);
    rd(12'h000, r);
    chk({r[31], r[3:0]}, 5'h00, "R7 clear-power-off at idle ignored");
    // R9 R10 R11 sticky flags
    wr(12'h400, (32'h1 << 28) | (32'h1 << 26) | (32'h1 << 24) | (32'h1 << 22)
                | (32'h1 << 21) | (32'h1 << 20) | (32'h1 << 29));
    rd(12'h400, r);
    chk(r & 32'h15F0_0000, 32'h1570_0000, "R9 flags set");
    chk(r & 32'h6A88_0000, 32'h0, "R10 command bits read zero");
    chk(r[7:4], 4'b1001, "R11 new=2 old=1 with secure enter");
    wr(12'h000, (32'h1 << 27) | (32'h1 << 25));
    rd(12'h400, r);
    chk(r & 32'h15F0_0000, 32'h1570_0000, "R9 normal word cannot clear flags");
    wr(12'h400, (32'h1 << 27) | (32'h1 << 25) | (32'h1 << 23) | (32'h1 << 19));
    rd(12'h000, r);
    chk(r & 32'h15F0_0000, 32'h0060_0000, "R9 flags cleared");
    chk(r[7:6], 2'd1, "R11 new mode back to 1");
    wr(12'h400, (32'h1 << 28) | (32'h1 << 27));
    rd(12'h000, r);
    chk(r[28], 1'b0, "R9 clear wins over set");
    // R4 power-off
    push(3'b101, ISO); push(3'b110, 0);
    wr(12'h400, 32'h1 << 30);
    rd(12'h400, r);
    chk(r[3:0], 4'hC, "R4 isolating for power-off");
    chk(r[16:10], 7'd3, "R4 step index 3");
    repeat (ISO) @(negedge clk);
    rd(12'h400, r);
    chk(r[3:0], 4'hD, "R4 powered off");
    chk(r[16:10], 7'd4, "R4 step index 4");
    chk(r[7:4], 4'b0001, "R11 new=0 old=1 after power-off");
    chk(r[9:8], 2'b00, "R12 hub status off");
    chk(core_irq, 1'b1, "R8 interrupt after power-off");
    wr(12'h000, 32'h4);
    wr(12'h400, 32'h1 << 30);
    rd(12'h000, r);
    chk(r[3:0], 4'hD, "R7 requests in off ignored");
    rd(12'h200, r);
    chk(r, 32'h0, "R2 unmapped address reads zero");
    push(3'b001, 0);
    wr(12'h400, 32'h1 << 29);
    rd(12'h000, r);
    chk(r[3:0], 4'h0, "R5 second power-up");
    repeat (4) @(negedge clk);
    chk(q.size(), 0, "R6 all expected output changes seen");
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule